// File: doc/BRIEF.md
# Battery Capacity Status Flag Controller

This block keeps the flags and the charge-cycle counter that describe two things about a battery. The first is how far the stored capacity reference can be trusted. The second is how close the cell is to empty.

It receives single-cycle event strobes from the surrounding gauge logic:
- a valid charge;
- a new capacity reference taken after a qualified full discharge;
- a gauge initialise request;
- the crossings of the first and final end-of-discharge thresholds;
- the detection of a battery being replaced.

It also receives a level that is high while the battery is detected as removed. The comparators that produce these strobes sit outside the block.

The block holds the capacity reference itself. On initialisation the reference is loaded from the programmed full count, and it is replaced whenever a qualified discharge delivers a measured value. An 8-bit counter counts the valid charges seen since the last reference update. When that count reaches a limit, a flag warns that the reference has gone stale. The end-of-discharge flags stay latched until the battery is charged again. The final one also releases the empty pin to high impedance.

Every output is registered. An event applied before a rising clock edge shows at the outputs just after that edge.

Top module: `cap_status_flags`

## Requirements
- R1: While `rst_n` is low, or in a cycle with `initEvt` high, the next edge sets `capInaccFlag`=1 and `replacedFlag`=1. The same edge sets `cycleCount`=0, `edv1Flag`=0, `edvfFlag`=0, `removedFlag`=0 and `emptyHiZ`=0, and loads `capRef` with `progFull`. This has priority over every other input in the same cycle.
- R2: Each cycle with `validCharge`=1 and `refUpdate`=0 raises `cycleCount` by one. At 255 the count holds and does not wrap. In any other cycle without initialisation or reference update, the count does not change.
- R3: A cycle with `refUpdate`=1 loads `capRef` with `refValue`, clears `cycleCount` to 0 and clears `capInaccFlag`. This happens even when `validCharge` is high in the same cycle. `capRef` changes only through R1 and R3.
- R4: `capInaccFlag` is set by the valid charge that brings `cycleCount` from 63 to 64. Once set, it stays set until a reference update or initialisation.
- R5: `edv1Flag` is set by `edv1Cross` and is cleared only by a cycle with `validCharge`=1 and `edv1Cross`=0. A crossing in the same cycle as a charge leaves the flag set.
- R6: `edvfFlag` follows the same latch rule as R5, using `edvfCross`.
- R7: `emptyHiZ` is 1 exactly when `edvfFlag` is 1.
- R8: `replacedFlag` is set by `replacedDet`. It is cleared by a cycle with `validCharge`=1 and `replacedDet`=0 in which `availCharge` equals the `capRef` value held before that edge. Otherwise it holds.
- R9: `removedFlag` equals the `removedCond` value from the previous cycle, outside initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, same effect as `initEvt` |
| initEvt | input | 1 | Gauge initialise strobe |
| validCharge | input | 1 | Valid charge event strobe |
| refUpdate | input | 1 | Qualified-discharge capacity reference update strobe |
| refValue | input | 16 | New capacity reference value |
| progFull | input | 16 | Programmed full count |
| availCharge | input | 16 | Current available charge |
| edv1Cross | input | 1 | First end-of-discharge threshold crossed |
| edvfCross | input | 1 | Final end-of-discharge threshold crossed |
| replacedDet | input | 1 | Battery replaced detected |
| removedCond | input | 1 | Battery removed condition level |
| capInaccFlag | output | 1 | Capacity reference is stale |
| replacedFlag | output | 1 | Battery replaced flag |
| removedFlag | output | 1 | Battery removed flag |
| edv1Flag | output | 1 | First end-of-discharge flag |
| edvfFlag | output | 1 | Final end-of-discharge flag |
| emptyHiZ | output | 1 | Empty pin high-impedance enable |
| cycleCount | output | 8 | Charges since the last reference update, saturating |
| capRef | output | 16 | Capacity reference |

## Verification
Every piece of state in this block is also an output, so a wrong internal value appears at the ports on the first edge after the event that caused it. Two kinds of fault are slower to show.

- **Counter off by one or wrapping.** A counter that counts one too many or wraps only becomes visible when the count nears 64 or 255. The bench therefore drives long runs of charges with no reference update.
- **Wrong priority between two events.** A bad choice of winner shows only when both events arrive in the same cycle. The bench applies these pairs deliberately: update with charge, crossing with charge, initialise with anything.

A reference-match error shows only when `availCharge` equals `capRef`. The stimulus presents that equality often.

// File: rtl/cap_status_flags_pkg.sv
package cap_status_flags_pkg;

  // Strobes from control to datapath, already prioritised.
  typedef struct packed {
    logic loadInit;   // load programmed full count, clear counter
    logic loadRef;    // load measured reference, clear counter
    logic bumpCount;  // count one valid charge (saturating)
  } dpStrobe_t;

endpackage

// File: rtl/cap_status_flags_dp.sv
module cap_status_flags_dp
  import cap_status_flags_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int REF_W    = 16,
  parameter int CI_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobes,
  input  logic [REF_W-1:0] refValue,
  input  logic [REF_W-1:0] progFull,
  input  logic [REF_W-1:0] availCharge,
  output logic [CNT_W-1:0] cycleCount,
  output logic [REF_W-1:0] capRef,
  output logic             hitLimit,
  output logic             refMatch
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT_PRE = CNT_W'(CI_LIMIT - 1);

  logic atMax;

  assign atMax    = (cycleCount == CNT_MAX);
  // next bump will land exactly on the limit
  assign hitLimit = (cycleCount == LIMIT_PRE);
  assign refMatch = (availCharge == capRef);

  always_ff @(posedge clk) begin
    if (strobes.loadInit) begin
      cycleCount <= '0;
      capRef     <= progFull;
    end else if (strobes.loadRef) begin
      cycleCount <= '0;
      capRef     <= refValue;
    end else if (strobes.bumpCount && !atMax) begin
      cycleCount <= cycleCount + 1'b1;
    end
  end

  assert_count_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleCount == CNT_MAX && !strobes.loadInit && !strobes.loadRef) |=> (cycleCount == CNT_MAX));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.bumpCount && !atMax) |=> (cycleCount == $past(cycleCount) + 1'b1));

  assert_ref_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadRef |=> (cycleCount == '0 && capRef == $past(refValue)));

  assert_ref_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.loadInit && !strobes.loadRef) |=> $stable(capRef));

endmodule

// File: rtl/cap_status_flags_ctrl.sv
module cap_status_flags_ctrl
  import cap_status_flags_pkg::*;
#(
  parameter int EMPTY_LEVELS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    initEvt,
  input  logic                    validCharge,
  input  logic                    refUpdate,
  input  logic [EMPTY_LEVELS-1:0] emptyCross,
  input  logic                    replacedDet,
  input  logic                    removedCond,
  input  logic                    hitLimit,
  input  logic                    refMatch,
  output dpStrobe_t               strobes,
  output logic                    capInaccFlag,
  output logic                    replacedFlag,
  output logic                    removedFlag,
  output logic [EMPTY_LEVELS-1:0] emptyFlags
);

  logic initAll;

  assign initAll = !rst_n || initEvt;

  always_comb begin
    strobes.loadInit  = initAll;
    strobes.loadRef   = refUpdate && !initAll;
    strobes.bumpCount = validCharge && !refUpdate && !initAll;
  end

  // capacity-inaccurate, replaced and removed flags
  always_ff @(posedge clk) begin
    if (initAll) begin
      capInaccFlag <= 1'b1;
      replacedFlag <= 1'b1;
      removedFlag  <= 1'b0;
    end else begin
      removedFlag <= removedCond;
      if (strobes.loadRef)
        capInaccFlag <= 1'b0;
      else if (strobes.bumpCount && hitLimit)
        capInaccFlag <= 1'b1;
      if (replacedDet)
        replacedFlag <= 1'b1;
      else if (validCharge && refMatch)
        replacedFlag <= 1'b0;
    end
  end

  // one latch per end-of-discharge level: set on crossing, cleared by charge
  for (genvar lvl = 0; lvl < EMPTY_LEVELS; lvl++) begin : g_emptyLatch
    always_ff @(posedge clk) begin
      if (initAll)
        emptyFlags[lvl] <= 1'b0;
      else if (emptyCross[lvl])
        emptyFlags[lvl] <= 1'b1;
      else if (validCharge)
        emptyFlags[lvl] <= 1'b0;
    end

    assert_empty_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (emptyFlags[lvl] && !validCharge && !initEvt) |=> emptyFlags[lvl]);

    assert_empty_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (validCharge && !emptyCross[lvl] && !initEvt) |=> !emptyFlags[lvl]);
  end

  assert_init_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    initEvt |=> (capInaccFlag && replacedFlag && !removedFlag && emptyFlags == '0));

  assert_removed_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !initEvt |=> (removedFlag == $past(removedCond)));

  assert_replaced_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    replacedDet |=> replacedFlag);

  assert_ci_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (refUpdate && !initEvt) |=> !capInaccFlag);

endmodule

// File: rtl/cap_status_flags.sv
module cap_status_flags
  import cap_status_flags_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int REF_W    = 16,
  parameter int CI_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             initEvt,
  input  logic             validCharge,
  input  logic             refUpdate,
  input  logic [REF_W-1:0] refValue,
  input  logic [REF_W-1:0] progFull,
  input  logic [REF_W-1:0] availCharge,
  input  logic             edv1Cross,
  input  logic             edvfCross,
  input  logic             replacedDet,
  input  logic             removedCond,
  output logic             capInaccFlag,
  output logic             replacedFlag,
  output logic             removedFlag,
  output logic             edv1Flag,
  output logic             edvfFlag,
  output logic             emptyHiZ,
  output logic [CNT_W-1:0] cycleCount,
  output logic [REF_W-1:0] capRef
);

  localparam int EMPTY_LEVELS = 2;

  dpStrobe_t               strobes;
  logic                    hitLimit;
  logic                    refMatch;
  logic [EMPTY_LEVELS-1:0] emptyFlags;

  cap_status_flags_ctrl #(.EMPTY_LEVELS(EMPTY_LEVELS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .initEvt      (initEvt),
    .validCharge  (validCharge),
    .refUpdate    (refUpdate),
    .emptyCross   ({edvfCross, edv1Cross}),
    .replacedDet  (replacedDet),
    .removedCond  (removedCond),
    .hitLimit     (hitLimit),
    .refMatch     (refMatch),
    .strobes      (strobes),
    .capInaccFlag (capInaccFlag),
    .replacedFlag (replacedFlag),
    .removedFlag  (removedFlag),
    .emptyFlags   (emptyFlags)
  );

  cap_status_flags_dp #(.CNT_W(CNT_W), .REF_W(REF_W), .CI_LIMIT(CI_LIMIT)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .refValue    (refValue),
    .progFull    (progFull),
    .availCharge (availCharge),
    .cycleCount  (cycleCount),
    .capRef      (capRef),
    .hitLimit    (hitLimit),
    .refMatch    (refMatch)
  );

  assign edv1Flag = emptyFlags[0];
  assign edvfFlag = emptyFlags[1];
  // final empty level releases the empty pin
  assign emptyHiZ = emptyFlags[1];

  assert_ci_on_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (validCharge && !refUpdate && !initEvt && cycleCount == CNT_W'(CI_LIMIT - 1)) |=> capInaccFlag);

  assert_ci_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capInaccFlag && !refUpdate) |=> capInaccFlag);

  assert_hiz_on_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edvfCross && !initEvt) |=> emptyHiZ);

  assert_init_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    initEvt |=> (capRef == $past(progFull) && cycleCount == '0 && !emptyHiZ));

endmodule

// File: tb/cap_status_flags_bench.sv
`timescale 1ns/1ps
module cap_status_flags_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        initEvt = 1'b0, validCharge = 1'b0, refUpdate = 1'b0;
  logic [15:0] refValue = '0, progFull = 16'd49152, availCharge = '0;
  logic        edv1Cross = 1'b0, edvfCross = 1'b0, replacedDet = 1'b0, removedCond = 1'b0;
  logic        capInaccFlag, replacedFlag, removedFlag, edv1Flag, edvfFlag, emptyHiZ;
  logic [7:0]  cycleCount;
  logic [15:0] capRef;

  int vectors = 0;
  int fails   = 0;

  // reference model state
  logic        mCi, mRep, mRem, mE1, mEf;
  logic [7:0]  mCnt;
  logic [15:0] mRef;

  always #5 clk = ~clk;

  cap_status_flags u_cap_status_flags (
    .clk(clk), .rst_n(rst_n), .initEvt(initEvt), .validCharge(validCharge),
    .refUpdate(refUpdate), .refValue(refValue), .progFull(progFull),
    .availCharge(availCharge), .edv1Cross(edv1Cross), .edvfCross(edvfCross),
    .replacedDet(replacedDet), .removedCond(removedCond),
    .capInaccFlag(capInaccFlag), .replacedFlag(replacedFlag), .removedFlag(removedFlag),
    .edv1Flag(edv1Flag), .edvfFlag(edvfFlag), .emptyHiZ(emptyHiZ),
    .cycleCount(cycleCount), .capRef(capRef)
  );

  function automatic logic [7:0] satInc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  task automatic modelStep();
    if (!rst_n || initEvt) begin
      mCi = 1; mRep = 1; mRem = 0; mE1 = 0; mEf = 0; mCnt = 0; mRef = progFull;
    end else begin
      mRem = removedCond;
      if (replacedDet) mRep = 1;
      else if (validCharge && availCharge == mRef) mRep = 0;
      if (edv1Cross) mE1 = 1; else if (validCharge) mE1 = 0;
      if (edvfCross) mEf = 1; else if (validCharge) mEf = 0;
      if (refUpdate) begin
        mCnt = 0; mCi = 0; mRef = refValue;
      end else if (validCharge) begin
        mCnt = satInc(mCnt);
        if (mCnt == 8'd64) mCi = 1;
      end
    end
  endtask

  task automatic chk1(input string req, input string nm, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    vectors++;
    chk1("R4", "capInaccFlag", capInaccFlag, mCi);
    chk1("R8", "replacedFlag", replacedFlag, mRep);
    chk1("R9", "removedFlag", removedFlag, mRem);
    chk1("R5", "edv1Flag", edv1Flag, mE1);
    chk1("R6", "edvfFlag", edvfFlag, mEf);
    chk1("R7", "emptyHiZ", emptyHiZ, mEf);
    if (cycleCount !== mCnt) begin
      fails++;
      $display("FAIL R2 cycleCount actual=%0d expected=%0d t=%0t", cycleCount, mCnt, $time);
    end
    if (capRef !== mRef) begin
      fails++;
      $display("FAIL R3 capRef actual=%0d expected=%0d t=%0t", capRef, mRef, $time);
    end
  endtask

  // apply inputs at the falling edge, check just after the next rising edge
  task automatic step(input logic ie, input logic vc, input logic ru, input logic [15:0] rv,
                      input logic [15:0] av, input logic e1, input logic ef,
                      input logic rd, input logic rc);
    @(negedge clk);
    initEvt = ie; validCharge = vc; refUpdate = ru; refValue = rv; availCharge = av;
    edv1Cross = e1; edvfCross = ef; replacedDet = rd; removedCond = rc;
    modelStep();
    @(posedge clk);
    #1;
    checkAll();
  endtask

  task automatic idle();
    step(0, 0, 0, 16'd0, 16'hFFFF, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stimulus
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) begin
      @(negedge clk); modelStep();
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    vectors++;
    if (!(capInaccFlag === 1 && replacedFlag === 1 && cycleCount === 0 && capRef === 16'd49152
          && edv1Flag === 0 && edvfFlag === 0 && removedFlag === 0 && emptyHiZ === 0)) begin
      fails++;
      $display("FAIL R1 reset state actual ci=%0b rep=%0b cnt=%0d ref=%0d expected 1 1 0 49152",
               capInaccFlag, replacedFlag, cycleCount, capRef);
    end
    // R3: update clears flag and counter
    step(0, 0, 1, 16'd30000, 16'd0, 0, 0, 0, 0);
    // R4: 63 charges leave flag low, 64th sets it
    repeat (63) step(0, 1, 0, 16'd0, 16'd1, 0, 0, 0, 0);
    vectors++;
    if (capInaccFlag !== 1'b0) begin
      fails++; $display("FAIL R4 after 63 charges actual=%0b expected=0", capInaccFlag);
    end
    step(0, 1, 0, 16'd0, 16'd1, 0, 0, 0, 0);
    vectors++;
    if (capInaccFlag !== 1'b1) begin
      fails++; $display("FAIL R4 on 64th charge actual=%0b expected=1", capInaccFlag);
    end
    // R2: saturation at 255
    repeat (200) step(0, 1, 0, 16'd0, 16'd1, 0, 0, 0, 0);
    vectors++;
    if (cycleCount !== 8'd255) begin
      fails++; $display("FAIL R2 saturation actual=%0d expected=255", cycleCount);
    end
    idle();
    // R3: update wins over same-cycle charge
    step(0, 1, 1, 16'd12345, 16'd0, 0, 0, 0, 0);
    vectors++;
    if (cycleCount !== 8'd0 || capRef !== 16'd12345) begin
      fails++; $display("FAIL R3 update+charge actual cnt=%0d ref=%0d expected 0 12345", cycleCount, capRef);
    end
    // R5/R6/R7: latch, crossing with charge stays set, charge alone clears
    step(0, 0, 0, 16'd0, 16'd0, 1, 1, 0, 0);
    idle(); idle();
    step(0, 1, 0, 16'd0, 16'd0, 1, 0, 0, 0);
    vectors++;
    if (edv1Flag !== 1'b1 || edvfFlag !== 1'b0 || emptyHiZ !== 1'b0) begin
      fails++; $display("FAIL R5 crossing+charge actual e1=%0b ef=%0b hz=%0b expected 1 0 0", edv1Flag, edvfFlag, emptyHiZ);
    end
    step(0, 1, 0, 16'd0, 16'd0, 0, 0, 0, 0);
    // R8: charge with mismatch keeps, match clears
    step(0, 0, 0, 16'd0, 16'd0, 0, 0, 1, 0);
    step(0, 1, 0, 16'd0, 16'd5, 0, 0, 0, 0);
    step(0, 1, 0, 16'd0, 16'd12345, 0, 0, 0, 0);
    vectors++;
    if (replacedFlag !== 1'b0) begin
      fails++; $display("FAIL R8 match clear actual=%0b expected=0", replacedFlag);
    end
    // R9: removed follows
    step(0, 0, 0, 16'd0, 16'd0, 0, 0, 0, 1);
    step(0, 0, 0, 16'd0, 16'd0, 0, 0, 0, 0);
    // R1: init strobe beats everything
    step(1, 1, 1, 16'd7, 16'd7, 1, 1, 1, 1);
    // random mix
    for (int i = 0; i < 20000; i++) begin
      logic [15:0] av;
      av = ($urandom % 4 == 0) ? mRef : 16'($urandom);
      step(($urandom % 700) == 0, ($urandom % 3) != 0, ($urandom % 120) == 0,
           16'($urandom), av, ($urandom % 40) == 0, ($urandom % 60) == 0,
           ($urandom % 50) == 0, ($urandom % 8) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule